// File: doc/BRIEF.md
# Packet Sample Store with Block Interrupt

The block receives a stream of 6-bit voltage samples grouped into packets, one packet per full round of a conversion sequence. Each sample accepted on a valid beat is kept in an eight-entry register array. The entry is chosen by the sample's position inside the packet, not by the channel that produced it. A start-of-packet beat always lands in slot 0, and each later beat goes to the next slot. The stream source gets no backpressure: every valid beat is taken.

Software reads the array through a 32-bit, word-addressed memory-mapped slave port. Read data is registered and returns one cycle after the read strobe.

When a packet has been fully stored, a sticky status flag is raised. The flag drives the interrupt line only while the interrupt enable bit is set. With the enable cleared, software can poll the flag instead. Software clears the flag by writing 1 to it.

Top module: `sample_store`

## Requirements
- R1: After reset, word offsets 0 to 7 read 0, offset 8 (interrupt enable) reads 1, offset 9 (status) reads 0, and `irq_o` is low.
- R2: A valid beat with `st_sop_i` high stores its sample in slot 0. Each following valid beat without start-of-packet stores in the next slot (1, 2, …). Slot k is read at word offset k.
- R3: The slot pointer saturates at 7: further valid beats without start-of-packet overwrite slot 7 and leave slots 0 to 6 untouched.
- R4: A beat with `st_valid_i` low stores nothing and does not set status, whatever the other stream inputs carry.
- R5: A sample word returns the sample in bits 5:0 and zeros in bits 31:6.
- R6: A valid beat with `st_eop_i` high sets status bit 0 (offset 9) on that clock edge.
- R7: Writing a word with bit 0 set to offset 9 clears the status bit. Writing bit 0 as 0 leaves it unchanged.
- R8: If an end-of-packet beat and a status clear fall in the same cycle, the status bit ends up set.
- R9: `irq_o` is high exactly when status bit 0 and enable bit 0 (offset 8, written through bit 0) are both 1. With the enable at 0, status still reads 1 after a packet ends.
- R10: `csr_rdata_o` changes only on the clock edge that samples `csr_read_i`. It then holds the addressed word until the next read. Offsets 10 to 15 read 0.
- R11: Writes to offsets 0 to 7 leave the stored samples unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_valid_i | input | 1 | Stream beat valid |
| st_sop_i | input | 1 | Beat is first of a packet |
| st_eop_i | input | 1 | Beat is last of a packet |
| st_data_i | input | 6 | Sample value |
| csr_addr_i | input | 4 | Word address |
| csr_read_i | input | 1 | Read strobe |
| csr_write_i | input | 1 | Write strobe |
| csr_wdata_i | input | 32 | Write data |
| csr_rdata_o | output | 32 | Read data, one cycle after the strobe |
| irq_o | output | 1 | Level interrupt, status AND enable |

## Verification
Two events can hit the status flag in the same cycle: an end-of-packet beat setting it and a software write clearing it. The bench drives a valid end-of-packet beat and a write of 1 to offset 9 on the same clock edge. It then reads the status back and expects it set, with the interrupt high. Checks before and after that case confirm that each action works on its own.

// File: rtl/ss_pkg.sv
package ss_pkg;
  // read source selected by the CSR address
  typedef enum logic [1:0] {
    SEL_SLOT = 2'd0,
    SEL_EN   = 2'd1,
    SEL_STS  = 2'd2,
    SEL_NONE = 2'd3
  } rd_sel_e;

  function automatic rd_sel_e decode_addr(input int unsigned addr, input int unsigned depth);
    if (addr < depth)           return SEL_SLOT;
    else if (addr == depth)     return SEL_EN;
    else if (addr == depth + 1) return SEL_STS;
    else                        return SEL_NONE;
  endfunction
endpackage

// File: rtl/ss_slot_wr.sv
module ss_slot_wr #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned SMP_W = 6,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            valid_i,
  input  logic                            sop_i,
  input  logic [SMP_W-1:0]                data_i,
  output logic [DEPTH-1:0][SMP_W-1:0]     slots_o,
  output logic [PTR_W-1:0]                ptr_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] ptr_q, ptr_d, idx;

  assign idx   = sop_i ? '0 : ptr_q;
  assign ptr_d = (idx == LAST) ? LAST : idx + PTR_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ptr_q <= '0;
    else if (valid_i) ptr_q <= ptr_d;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [SMP_W-1:0] slot_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 slot_q <= '0;
      else if (valid_i && idx == PTR_W'(g))        slot_q <= data_i;
    end
    assign slots_o[g] = slot_q;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/ss_irq_regs.sv
module ss_irq_regs (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic eop_evt_i,
  input  logic en_wr_i,
  input  logic sts_wr_i,
  input  logic wbit_i,
  output logic en_o,
  output logic sts_o,
  output logic irq_o
);
  logic en_q, sts_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= 1'b1;
    else if (en_wr_i) en_q <= wbit_i;
  end

  // set has priority over write-1-to-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  sts_q <= 1'b0;
    else if (eop_evt_i)           sts_q <= 1'b1;
    else if (sts_wr_i && wbit_i)  sts_q <= 1'b0;
  end

  assign en_o  = en_q;
  assign sts_o = sts_q;
  assign irq_o = en_q & sts_q;
endmodule

// File: rtl/ss_csr_rd.sv
module ss_csr_rd
  import ss_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned SMP_W  = 6,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        rd_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [DEPTH-1:0][SMP_W-1:0] slots_i,
  input  logic                        en_i,
  input  logic                        sts_i,
  output logic [DATA_W-1:0]           rdata_o
);
  rd_sel_e           sel;
  logic [DATA_W-1:0] word, rdata_q;

  assign sel = decode_addr(int'(addr_i), DEPTH);

  always_comb begin
    word = '0;
    unique case (sel)
      SEL_SLOT: word[SMP_W-1:0] = slots_i[addr_i[PTR_W-1:0]];
      SEL_EN:   word[0] = en_i;
      SEL_STS:  word[0] = sts_i;
      default:  word = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= word;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/sample_store.sv
module sample_store
  import ss_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned SMP_W  = 6,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned ADDR_W = $clog2(DEPTH + 2),
  localparam int unsigned PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              st_valid_i,
  input  logic              st_sop_i,
  input  logic              st_eop_i,
  input  logic [SMP_W-1:0]  st_data_i,
  input  logic [ADDR_W-1:0] csr_addr_i,
  input  logic              csr_read_i,
  input  logic              csr_write_i,
  input  logic [DATA_W-1:0] csr_wdata_i,
  output logic [DATA_W-1:0] csr_rdata_o,
  output logic              irq_o
);
  logic [DEPTH-1:0][SMP_W-1:0] slots;
  logic [PTR_W-1:0]            wr_ptr;
  logic                        irq_en, irq_sts;
  logic                        en_wr, sts_wr;
  rd_sel_e                     wr_sel;
  logic                        unused_wdata;

  assign wr_sel       = decode_addr(int'(csr_addr_i), DEPTH);
  assign en_wr        = csr_write_i && (wr_sel == SEL_EN);
  assign sts_wr       = csr_write_i && (wr_sel == SEL_STS);
  assign unused_wdata = ^csr_wdata_i[DATA_W-1:1];

  ss_slot_wr #(.DEPTH(DEPTH), .SMP_W(SMP_W)) i_slot_wr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (st_valid_i),
    .sop_i   (st_sop_i),
    .data_i  (st_data_i),
    .slots_o (slots),
    .ptr_o   (wr_ptr)
  );

  ss_irq_regs i_irq_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .eop_evt_i (st_valid_i & st_eop_i),
    .en_wr_i   (en_wr),
    .sts_wr_i  (sts_wr),
    .wbit_i    (csr_wdata_i[0]),
    .en_o      (irq_en),
    .sts_o     (irq_sts),
    .irq_o     (irq_o)
  );

  ss_csr_rd #(.DEPTH(DEPTH), .SMP_W(SMP_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_csr_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_i    (csr_read_i),
    .addr_i  (csr_addr_i),
    .slots_i (slots),
    .en_i    (irq_en),
    .sts_i   (irq_sts),
    .rdata_o (csr_rdata_o)
  );
endmodule

// File: rtl/ss_checker.sv
module ss_checker #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned PTR_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              st_valid_i,
  input logic              st_sop_i,
  input logic              st_eop_i,
  input logic [ADDR_W-1:0] csr_addr_i,
  input logic              csr_read_i,
  input logic              csr_write_i,
  input logic              wbit_i,
  input logic [DATA_W-1:0] csr_rdata_o,
  input logic              irq_o,
  input logic [PTR_W-1:0]  wr_ptr,
  input logic              irq_en,
  input logic              irq_sts
);
  localparam logic [PTR_W-1:0]  LAST    = PTR_W'(DEPTH - 1);
  localparam logic [ADDR_W-1:0] STS_OFS = ADDR_W'(DEPTH + 1);

  AST_SOP_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_valid_i && st_sop_i |=> wr_ptr == PTR_W'(1));                       // R2

  AST_PTR_SATURATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_valid_i && !st_sop_i && wr_ptr == LAST |=> wr_ptr == LAST);        // R3

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !st_valid_i |=> $stable(wr_ptr));                                     // R4

  AST_EOP_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_valid_i && st_eop_i |=> irq_sts);                                  // R6 R8

  AST_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_write_i && csr_addr_i == STS_OFS && wbit_i && !(st_valid_i && st_eop_i)
    |=> !irq_sts);                                                        // R7

  AST_IRQ_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en |-> !irq_o);                                                  // R9

  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_read_i && csr_addr_i > STS_OFS |=> csr_rdata_o == '0);            // R10

  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !csr_read_i |=> $stable(csr_rdata_o));                                // R10
endmodule

bind sample_store ss_checker #(
  .DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PTR_W(PTR_W)
) i_ss_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .st_valid_i  (st_valid_i),
  .st_sop_i    (st_sop_i),
  .st_eop_i    (st_eop_i),
  .csr_addr_i  (csr_addr_i),
  .csr_read_i  (csr_read_i),
  .csr_write_i (csr_write_i),
  .wbit_i      (csr_wdata_i[0]),
  .csr_rdata_o (csr_rdata_o),
  .irq_o       (irq_o),
  .wr_ptr      (wr_ptr),
  .irq_en      (irq_en),
  .irq_sts     (irq_sts)
);

// File: tb/test_sample_store.sv
module test_sample_store;
  localparam time CLK_PERIOD = 10ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        st_valid_i = 1'b0, st_sop_i = 1'b0, st_eop_i = 1'b0;
  logic [5:0]  st_data_i = '0;
  logic [3:0]  csr_addr_i = '0;
  logic        csr_read_i = 1'b0, csr_write_i = 1'b0;
  logic [31:0] csr_wdata_i = '0;
  logic [31:0] csr_rdata_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sample_store i_sample_store (
    .clk_i, .rst_ni, .st_valid_i, .st_sop_i, .st_eop_i, .st_data_i,
    .csr_addr_i, .csr_read_i, .csr_write_i, .csr_wdata_i, .csr_rdata_o, .irq_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic beat(input logic v, input logic sop, input logic eop, input logic [5:0] d);
    @(negedge clk_i);
    st_valid_i = v; st_sop_i = sop; st_eop_i = eop; st_data_i = d;
    @(posedge clk_i); #1;
    st_valid_i = 1'b0; st_sop_i = 1'b0; st_eop_i = 1'b0;
  endtask

  task automatic csr_rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk_i);
    csr_addr_i = a; csr_read_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    csr_read_i = 1'b0;
    d = csr_rdata_o;
  endtask

  task automatic csr_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk_i);
    csr_addr_i = a; csr_wdata_i = d; csr_write_i = 1'b1;
    @(posedge clk_i); #1;
    csr_write_i = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int i = 0; i < 8; i++) begin
      csr_rd(4'(i), d);
      chk("R1 slot reset", d, 32'h0);
    end
    csr_rd(4'd8, d); chk("R1 enable reset", d, 32'h1);
    csr_rd(4'd9, d); chk("R1 status reset", d, 32'h0);
    chk("R1 irq reset", 32'(irq_o), 32'h0);
  endtask

  task automatic t_packet;
    logic [31:0] d;
    for (int i = 0; i < 8; i++)
      beat(1'b1, i == 0, i == 7, (i == 3) ? 6'h3F : 6'(8'h11 + i));
    chk("R6 irq after eop", 32'(irq_o), 32'h1);
    for (int i = 0; i < 8; i++) begin
      csr_rd(4'(i), d);
      chk("R2 slot order", d, (i == 3) ? 32'h3F : 32'(8'h11 + i));
    end
    csr_rd(4'd3, d); chk("R5 upper bits zero", d & 32'hFFFF_FFC0, 32'h0);
    csr_rd(4'd9, d); chk("R6 status set", d, 32'h1);
  endtask

  task automatic t_clear;
    logic [31:0] d;
    csr_wr(4'd9, 32'hFFFF_FFFE);
    csr_rd(4'd9, d); chk("R7 write 0 keeps status", d, 32'h1);
    csr_wr(4'd9, 32'h1);
    csr_rd(4'd9, d); chk("R7 write 1 clears status", d, 32'h0);
    chk("R9 irq low after clear", 32'(irq_o), 32'h0);
  endtask

  task automatic t_set_wins;
    logic [31:0] d;
    @(negedge clk_i);
    st_valid_i = 1'b1; st_sop_i = 1'b1; st_eop_i = 1'b1; st_data_i = 6'h05;
    csr_addr_i = 4'd9; csr_wdata_i = 32'h1; csr_write_i = 1'b1;
    @(posedge clk_i); #1;
    st_valid_i = 1'b0; st_sop_i = 1'b0; st_eop_i = 1'b0; csr_write_i = 1'b0;
    chk("R8 irq with set and clear together", 32'(irq_o), 32'h1);
    csr_rd(4'd9, d); chk("R8 set wins", d, 32'h1);
    csr_wr(4'd9, 32'h1);
  endtask

  task automatic t_saturate;
    logic [31:0] d;
    for (int i = 0; i < 10; i++) beat(1'b1, i == 0, 1'b0, 6'(i + 1));
    csr_rd(4'd7, d); chk("R3 slot 7 overwritten", d, 32'd10);
    csr_rd(4'd6, d); chk("R3 slot 6 intact", d, 32'd7);
    csr_rd(4'd0, d); chk("R3 slot 0 intact", d, 32'd1);
  endtask

  task automatic t_invalid;
    logic [31:0] d;
    beat(1'b0, 1'b1, 1'b1, 6'h2A);
    chk("R4 no irq on idle beat", 32'(irq_o), 32'h0);
    csr_rd(4'd0, d); chk("R4 slot 0 untouched", d, 32'd1);
    csr_rd(4'd9, d); chk("R4 status untouched", d, 32'h0);
  endtask

  task automatic t_mask;
    logic [31:0] d;
    csr_wr(4'd8, 32'h0);
    beat(1'b1, 1'b1, 1'b1, 6'h15);
    chk("R9 irq masked", 32'(irq_o), 32'h0);
    csr_rd(4'd9, d); chk("R9 status pollable", d, 32'h1);
    csr_rd(4'd8, d); chk("R9 enable reads 0", d, 32'h0);
    csr_wr(4'd8, 32'h1);
    chk("R9 irq on re-enable", 32'(irq_o), 32'h1);
    csr_wr(4'd9, 32'h1);
    chk("R9 irq drops on clear", 32'(irq_o), 32'h0);
  endtask

  task automatic t_csr_misc;
    logic [31:0] d;
    csr_wr(4'd3, 32'h0000_003F);
    csr_rd(4'd3, d); chk("R11 sample write ignored", d, 32'd4);
    csr_rd(4'd1, d); chk("R10 read slot 1", d, 32'd2);
    @(negedge clk_i);
    csr_addr_i = 4'd3; csr_read_i = 1'b1;
    #1 chk("R10 rdata holds before edge", csr_rdata_o, 32'd2);
    @(posedge clk_i); @(negedge clk_i);
    csr_read_i = 1'b0;
    chk("R10 rdata after edge", csr_rdata_o, 32'd4);
    csr_rd(4'd12, d); chk("R10 unmapped reads 0", d, 32'h0);
    csr_rd(4'd15, d); chk("R10 top offset reads 0", d, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_packet();
    t_clear();
    t_set_wins();
    t_saturate();
    t_invalid();
    t_mask();
    t_csr_misc();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule